// File: doc/BRIEF.md
# Polled Multi-Port Packet Receive Controller

This block is the link-layer end of a byte-wide receive bus that is shared by several PHY ports, each sending packets. The ports do not signal on their own. The controller asks each port in turn by putting that port's number on a shared address bus. The port that is addressed replies on a single shared packet-available line in the next cycle. When a full sweep of addresses is done, the controller picks one ready port by round-robin. It puts that port's address on the bus with read enable high, and reads the packet until it sees the end marker.

Each byte that is accepted goes to a downstream byte stream with four things: a first flag, a last flag, an error flag and the number of the source port. The source port can pause inside a packet by dropping its valid strobe. After a packet ends, the controller follows a fixed release pattern of enable-hold, deselect and reselect. It then serves the other ports found ready in the same sweep, and starts a new sweep when none are left. Address 0x1F never names a port. The controller drives it whenever no port is being polled or selected.

Top module: `pkt_poll_rx`

## Requirements
- R1: While the synchronous active-low reset is held, `rx_addr` is 0x1F, `rx_en` is low and `out_valid` is low. The first cycle after release still shows 0x1F with `rx_en` low.
- R2: A sweep drives addresses 0 to NUM_PORTS-1 in that order, one per cycle, with `rx_en` low, then one cycle of 0x1F. The level of `rx_avail` in the cycle after a port's address is that port's ready answer.
- R3: In the cycle after a sweep's 0x1F cycle, if any port answered ready, the chosen port's address is driven with `rx_en` high. `rx_en` is never high with address 0x1F, and the address stays stable while `rx_en` stays high.
- R4: The chosen port is the first ready port after the last served port, counting upward and wrapping past NUM_PORTS-1 to 0. After reset, the last served port is taken to be NUM_PORTS-1.
- R5: A byte is forwarded only when `rx_en` and `rx_valid` are both high in a cycle. It appears on the outputs in the next cycle, with `out_first` equal to `rx_sop`, `out_last` equal to `rx_eop`, and `out_port` set to the selected port. A byte offered while `rx_en` is low gives no output beat.
- R6: Cycles with `rx_valid` low inside a packet give no beat and do not end the transfer.
- R7: If the end-of-packet byte is accepted in cycle e, then `rx_en` stays high in e+1. In e+2, `rx_en` is low while `rx_addr` already shows the next port, or 0x1F if there is none. In e+3, the next port's address is driven with `rx_en` high. This pattern is the same whichever port comes next.
- R8: All ports found ready in one sweep are served before another sweep starts. After the last of them, cycle e+3 starts a new sweep at address 0 with `rx_en` low.
- R9: `out_err` is high only on a beat whose input byte had `rx_err` and `rx_eop` both high. An error marker on a byte that is not the last gives no flag.
- R10: When no port answers ready, sweeps repeat back to back and `rx_en` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_addr | output | 5 | Shared port address: a poll target, the selected port, or 0x1F for none |
| rx_en | output | 1 | Read enable for the port on `rx_addr` |
| rx_avail | input | 1 | Ready answer from the port addressed in the previous cycle |
| rx_valid | input | 1 | Byte-valid strobe from the selected port |
| rx_data | input | 8 | Packet byte |
| rx_sop | input | 1 | First byte of a packet |
| rx_eop | input | 1 | Last byte of a packet |
| rx_err | input | 1 | Error marker, meaningful together with `rx_eop` |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | Beat is the first of a packet |
| out_last | output | 1 | Beat is the last of a packet |
| out_err | output | 1 | Packet ended with an error |
| out_port | output | 5 | Port the beat came from |

## Verification
The bench models every port as a packet source that behaves by the bus rules. It runs the following directed patterns:

- **No port ready.** This confirms the exact sweep order and the 0x1F slot.
- **One ready port in the middle of the range.** A poll answer credited to a neighbouring port would pick the wrong address.
- **Three ready ports with uneven packet lengths.** This separates serving from the same sweep from re-polling, and it times the enable-hold, deselect and reselect pattern at each packet boundary.
- **A lone port followed by a group of ports behind it.** The service order must wrap instead of restarting at port 0.
- **Packets with a valid gap, with an error marker on a middle byte, or with an error marker on the last byte.** Together with junk bytes offered while enable is low, these separate the condition that takes a byte from the condition that sets the error flag.

// File: rtl/pkt_poll_rx_pkg.sv
// Package: shared types for the polled packet receive controller.
// Assumes: nothing beyond standard SystemVerilog.
package pkt_poll_rx_pkg;

    // Phases of the controller: sweeping, deciding, and the transfer bracket.
    typedef enum logic [2:0] {
        ST_POLL,   // drive one poll address per cycle
        ST_SCAN,   // null address, last poll answer arrives, arbitrate
        ST_SEL,    // chosen address with read enable
        ST_XFER,   // accept bytes until end of packet
        ST_TAIL,   // enable held one cycle after the last byte
        ST_DESEL   // enable low, next port shown or null
    } rx_state_e;

endpackage

// File: rtl/pkt_poll_rx_rr.sv
// Module: round-robin picker over a request vector.
// What it does: returns the first set request strictly after last_idx,
// wrapping past NUM_PORTS-1 to 0. Purely combinational.
// Assumes: last_idx < NUM_PORTS; clk/rst_n only clock its assertions.
module pkt_poll_rx_rr #(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] req,
    input  logic [ADDR_W-1:0]    last_idx,
    output logic                 grant_vld,
    output logic [ADDR_W-1:0]    grant_idx
);

    // Scan candidates in rotated order and keep the first hit.
    always_comb begin
        int cand;
        grant_vld = 1'b0;
        grant_idx = '0;
        cand      = 0;
        for (int i = 1; i <= NUM_PORTS; i++) begin
            cand = (int'(last_idx) + i) % NUM_PORTS;
            if (!grant_vld && |(req & (NUM_PORTS'(1) << cand))) begin
                grant_vld = 1'b1;
                grant_idx = ADDR_W'(cand);
            end
        end
    end

    // R4: a grant always points at a requesting port
    p_grant_is_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> |(req & (NUM_PORTS'(1) << grant_idx)));

    // R4: no grant only when nobody requests
    p_no_grant_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |-> (req == '0));

endmodule

// File: rtl/pkt_poll_rx_ctrl.sv
// Module: poll/select/transfer sequencer.
// What it does: sweeps port addresses, collects ready answers one cycle
// late, arbitrates, brackets each packet with the enable pattern, and
// serves the remaining ready ports of a sweep before sweeping again.
// Assumes: a selected port eventually sends an end-of-packet byte.
module pkt_poll_rx_ctrl
    import pkt_poll_rx_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_avail,
    input  logic              rx_valid,
    input  logic              rx_eop,
    output logic [ADDR_W-1:0] rx_addr,
    output logic              rx_en,
    output logic [ADDR_W-1:0] sel_port
);

    localparam logic [ADDR_W-1:0] NULL_ADDR = '1;
    localparam logic [ADDR_W-1:0] LAST_IDX  = ADDR_W'(NUM_PORTS - 1);

    rx_state_e              state;
    logic [ADDR_W-1:0]      poll_idx;
    logic [ADDR_W-1:0]      prev_idx;
    logic                   prev_vld;
    logic [NUM_PORTS-1:0]   ready_q;
    logic [NUM_PORTS-1:0]   pending_q;
    logic [NUM_PORTS-1:0]   full_ready;
    logic [NUM_PORTS-1:0]   req_mux;
    logic [ADDR_W-1:0]      sel_q;
    logic [ADDR_W-1:0]      rr_last;
    logic                   grant_vld;
    logic [ADDR_W-1:0]      grant_idx;

    // Merge this cycle's answer (for the previous poll address) into the set.
    always_comb begin
        full_ready = ready_q;
        if (prev_vld && rx_avail) begin
            full_ready = ready_q | (NUM_PORTS'(1) << prev_idx);
        end
    end

    // Arbitrate over the fresh sweep result or over what is still pending.
    assign req_mux = (state == ST_SCAN) ? full_ready : pending_q;

    pkt_poll_rx_rr #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W)
    ) u_rr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_mux),
        .last_idx  (rr_last),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    // Bus outputs are decoded from registers only.
    always_comb begin
        rx_addr = NULL_ADDR;
        rx_en   = 1'b0;
        unique case (state)
            ST_POLL:  rx_addr = poll_idx;
            ST_SCAN:  rx_addr = NULL_ADDR;
            ST_SEL, ST_XFER, ST_TAIL: begin
                rx_addr = sel_q;
                rx_en   = 1'b1;
            end
            ST_DESEL: rx_addr = grant_vld ? grant_idx : NULL_ADDR;
            default:  rx_addr = NULL_ADDR;
        endcase
    end

    assign sel_port = sel_q;

    // Sequencer state, sweep bookkeeping and grant capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_DESEL;
            poll_idx  <= '0;
            prev_idx  <= '0;
            prev_vld  <= 1'b0;
            ready_q   <= '0;
            pending_q <= '0;
            sel_q     <= NULL_ADDR;
            rr_last   <= LAST_IDX;
        end else begin
            prev_vld <= (state == ST_POLL);
            prev_idx <= poll_idx;
            case (state)
                ST_POLL: begin
                    ready_q <= full_ready;
                    if (poll_idx == LAST_IDX) begin
                        state <= ST_SCAN;
                    end else begin
                        poll_idx <= poll_idx + 1'b1;
                    end
                end
                ST_SCAN, ST_DESEL: begin
                    ready_q  <= '0;
                    poll_idx <= '0;
                    if (grant_vld) begin
                        state     <= ST_SEL;
                        sel_q     <= grant_idx;
                        rr_last   <= grant_idx;
                        pending_q <= req_mux & ~(NUM_PORTS'(1) << grant_idx);
                    end else begin
                        state     <= ST_POLL;
                        pending_q <= '0;
                    end
                end
                ST_SEL: state <= ST_XFER;
                ST_XFER: begin
                    if (rx_valid && rx_eop) begin
                        state <= ST_TAIL;
                    end
                end
                ST_TAIL: state <= ST_DESEL;
                default: state <= ST_DESEL;
            endcase
        end
    end

    // R1: reset parks the bus at the null address with enable low
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (rx_addr == NULL_ADDR && !rx_en));

    // R3: enable never accompanies the null address
    p_en_has_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en |-> (rx_addr != NULL_ADDR));

    // R3: address held while enable stays high
    p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $past(rx_en)) |-> $stable(rx_addr));

    // R7: after the last byte, enable holds one cycle and then drops
    p_eop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && rx_valid && rx_eop) |=> rx_en ##1 !rx_en);

endmodule

// File: rtl/pkt_poll_rx_capture.sv
// Module: output beat register.
// What it does: takes a byte only while enable and valid are both high
// and presents it one cycle later with its flags and source port.
// Assumes: sel_port is stable for the whole enable window.
module pkt_poll_rx_capture #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] sel_port,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic              rx_err,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              out_err,
    output logic [ADDR_W-1:0] out_port
);

    logic take;
    assign take = en && rx_valid;

    // Register one accepted byte per cycle; flags clear on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_err   <= 1'b0;
            out_port  <= '0;
        end else begin
            out_valid <= take;
            out_first <= take && rx_sop;
            out_last  <= take && rx_eop;
            out_err   <= take && rx_eop && rx_err;
            if (take) begin
                out_data <= rx_data;
                out_port <= sel_port;
            end
        end
    end

    // R5: bytes offered without enable never reach the output
    p_no_take_without_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !en) |=> !out_valid);

    // R9: the error flag only rides on a valid last beat
    p_err_on_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && out_last));

endmodule

// File: rtl/pkt_poll_rx.sv
// Module: top of the polled multi-port packet receive controller.
// What it does: ties the sequencer to the output beat register.
// Assumes: NUM_PORTS <= 31 so address 0x1F stays free as the null code.
module pkt_poll_rx #(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rx_addr,
    output logic              rx_en,
    input  logic              rx_avail,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic              rx_err,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              out_err,
    output logic [ADDR_W-1:0] out_port
);

    logic [ADDR_W-1:0] sel_port;

    pkt_poll_rx_ctrl #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_avail (rx_avail),
        .rx_valid (rx_valid),
        .rx_eop   (rx_eop),
        .rx_addr  (rx_addr),
        .rx_en    (rx_en),
        .sel_port (sel_port)
    );

    pkt_poll_rx_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .sel_port  (sel_port),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_sop    (rx_sop),
        .rx_eop    (rx_eop),
        .rx_err    (rx_err),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_first (out_first),
        .out_last  (out_last),
        .out_err   (out_err),
        .out_port  (out_port)
    );

endmodule

// File: tb/pkt_poll_rx_bench.sv
// Directed bench: a behavioural port model answers polls and sends packets.
module pkt_poll_rx_bench;

    localparam int NP = 4;
    localparam logic [4:0] NUL = 5'h1F;
    localparam int LOGN = 512;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [4:0] rx_addr;
    logic       rx_en;
    logic       rx_avail = 0;
    logic       rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic       rx_sop = 0, rx_eop = 0, rx_err = 0;
    logic       out_valid, out_first, out_last, out_err;
    logic [7:0] out_data;
    logic [4:0] out_port;

    pkt_poll_rx #(.NUM_PORTS(NP), .ADDR_W(5), .DATA_W(8)) u_pkt_poll_rx (
        .clk(clk), .rst_n(rst_n), .rx_addr(rx_addr), .rx_en(rx_en),
        .rx_avail(rx_avail), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err),
        .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
        .out_last(out_last), .out_err(out_err), .out_port(out_port)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;

    // port model configuration
    bit   pend [NP];
    int   plen [NP];
    logic [7:0] pbase [NP];
    bit   perr [NP];
    bit   perr_mid = 0;
    int   gap_at = -1;
    bit   junk = 0;
    // port model state
    int   active = -1, bi = 0, start_port = 0;
    bit   start_pend = 0, gap_done = 0;
    logic [4:0] prev_addr = NUL;
    logic prev_en = 0;
    // logs
    int   cyc = 0;
    logic en_log [LOGN];
    logic [4:0] addr_log [LOGN];
    int   eop_list [16];
    int   eop_n = 0;
    int   obs_n = 0;
    int   obs_cyc [64];
    logic [15:0] obs [64];   // {port, data, first, last, err}
    logic [15:0] expv [64];
    int   exp_n = 0;
    int   base = 0;

    // Monitor and port model, all on the falling edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        en_log[cyc % LOGN] = rx_en;
        addr_log[cyc % LOGN] = rx_addr;
        if (out_valid && obs_n < 64) begin
            obs[obs_n] = {out_port[4:0], out_data, out_first, out_last, out_err};
            obs_cyc[obs_n] = cyc;
            obs_n = obs_n + 1;
        end
        rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_err = 0; rx_data = 0;
        if (!rst_n) begin
            rx_avail = 0;
        end else begin
            rx_avail = (!prev_en && prev_addr < NP) ? pend[prev_addr] : 1'b0;
            if (start_pend) begin
                active = start_port; bi = 0; gap_done = 0; start_pend = 0;
            end
            if (junk) begin
                rx_valid = 1; rx_data = 8'hA5; rx_sop = 1; rx_eop = 1; rx_err = 1;
            end else if (active >= 0) begin
                if (bi == gap_at && !gap_done) begin
                    gap_done = 1;
                end else begin
                    rx_valid = 1;
                    rx_data = pbase[active] + 8'(bi);
                    rx_sop = (bi == 0);
                    rx_eop = (bi == plen[active] - 1);
                    rx_err = (rx_eop && perr[active]) || (perr_mid && bi == 1 && !rx_eop);
                    if (rx_eop) begin
                        if (eop_n < 16) eop_list[eop_n] = cyc;
                        eop_n = eop_n + 1;
                        active = -1;
                    end else begin
                        bi = bi + 1;
                    end
                end
            end
            if (rx_en && rx_addr < NP && active < 0 && !start_pend) begin
                if (pend[rx_addr]) begin
                    start_pend = 1; start_port = int'(rx_addr); pend[rx_addr] = 0;
                end
            end
        end
        prev_addr = rx_addr;
        prev_en = rx_en;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expd);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expd);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 0;
        for (int p = 0; p < NP; p++) begin
            pend[p] = 0; plen[p] = 1; pbase[p] = 0; perr[p] = 0;
        end
        perr_mid = 0; gap_at = -1; junk = 0;
        active = -1; start_pend = 0;
        tick(3);
        // R1: idle bus during reset
        chk(rx_addr == NUL && !rx_en && !out_valid, "R1", "reset outputs",
            {rx_addr, rx_en, out_valid}, {NUL, 2'b00});
        rst_n = 1;
        base = cyc + 1;
        obs_n = 0; exp_n = 0; eop_n = 0;
    endtask

    task automatic add_pkt(input int p, input int len, input logic [7:0] b, input bit e);
        for (int i = 0; i < len; i++) begin
            expv[exp_n] = {5'(p), b + 8'(i), (i == 0), (i == len - 1), (e && i == len - 1)};
            exp_n++;
        end
    endtask

    task automatic set_port(input int p, input int len, input logic [7:0] b, input bit e);
        plen[p] = len; pbase[p] = b; perr[p] = e; pend[p] = 1;
    endtask

    task automatic wait_beats(input int n);
        for (int k = 0; k < 400 && obs_n < n; k++) tick(1);
        tick(6);
    endtask

    task automatic cmp_beats(input string req);
        chk(obs_n == exp_n, req, "beat count", obs_n, exp_n);
        for (int i = 0; i < exp_n && i < obs_n; i++)
            chk(obs[i] === expv[i], req, $sformatf("beat %0d {port,data,f,l,e}", i),
                obs[i], expv[i]);
    endtask

    // Check the release pattern around the k-th end of packet.
    task automatic chk_release(input int k, input logic [4:0] nxt, input bit has_next);
        int e = eop_list[k];
        chk(en_log[(e + 1) % LOGN] == 1, "R7", "enable held after eop", en_log[(e + 1) % LOGN], 1);
        chk(en_log[(e + 2) % LOGN] == 0 && addr_log[(e + 2) % LOGN] == nxt, "R7",
            "deselect cycle {addr,en}", {addr_log[(e + 2) % LOGN], en_log[(e + 2) % LOGN]}, {nxt, 1'b0});
        if (has_next)
            chk(en_log[(e + 3) % LOGN] == 1 && addr_log[(e + 3) % LOGN] == nxt, "R7",
                "reselect {addr,en}", {addr_log[(e + 3) % LOGN], en_log[(e + 3) % LOGN]}, {nxt, 1'b1});
        else
            chk(en_log[(e + 3) % LOGN] == 0 && addr_log[(e + 3) % LOGN] == 0, "R8",
                "new sweep {addr,en}", {addr_log[(e + 3) % LOGN], en_log[(e + 3) % LOGN]}, 6'b0);
    endtask

    // R2, R10: idle sweeps
    task automatic t_idle();
        do_reset();
        tick(3 * (NP + 1) + 2);
        chk(addr_log[base % LOGN] == NUL, "R1", "first cycle after release", addr_log[base % LOGN], NUL);
        for (int k = 1; k <= 2 * (NP + 1); k++) begin
            int j = (k - 1) % (NP + 1);
            logic [4:0] ea = (j < NP) ? 5'(j) : NUL;
            chk(addr_log[(base + k) % LOGN] == ea && !en_log[(base + k) % LOGN], "R2",
                $sformatf("sweep cycle %0d {addr,en}", k),
                {addr_log[(base + k) % LOGN], en_log[(base + k) % LOGN]}, {ea, 1'b0});
        end
        for (int k = 0; k < 3 * (NP + 1); k++)
            if (en_log[(base + k) % LOGN]) chk(0, "R10", "enable while nothing ready", 1, 0);
        checks++;
    endtask

    // R3, R5, R8: one port in the middle
    task automatic t_single();
        do_reset();
        set_port(1, 5, 8'h40, 0);
        add_pkt(1, 5, 8'h40, 0);
        wait_beats(5);
        chk(!en_log[(base + 5) % LOGN] && addr_log[(base + 5) % LOGN] == NUL, "R2",
            "null slot after sweep", addr_log[(base + 5) % LOGN], NUL);
        chk(en_log[(base + 6) % LOGN] && addr_log[(base + 6) % LOGN] == 1, "R3",
            "select cycle {addr,en}", {addr_log[(base + 6) % LOGN], en_log[(base + 6) % LOGN]}, 6'b000011);
        chk(obs_cyc[0] == base + 8, "R5", "first beat cycle", obs_cyc[0] - base, 8);
        cmp_beats("R5");
        chk_release(0, NUL, 0);
    endtask

    // R7, R8: three ports from one sweep
    task automatic t_multi();
        do_reset();
        set_port(0, 3, 8'h10, 0);
        set_port(2, 4, 8'h20, 0);
        set_port(3, 2, 8'h30, 0);
        add_pkt(0, 3, 8'h10, 0);
        add_pkt(2, 4, 8'h20, 0);
        add_pkt(3, 2, 8'h30, 0);
        wait_beats(9);
        cmp_beats("R8");
        chk_release(0, 5'd2, 1);
        chk_release(1, 5'd3, 1);
        chk_release(2, NUL, 0);
    endtask

    // R4: wrap-around after a served port
    task automatic t_rr();
        do_reset();
        set_port(2, 2, 8'h50, 0);
        add_pkt(2, 2, 8'h50, 0);
        wait_beats(2);
        for (int k = 0; k < 50 && !(rx_addr == 0 && !rx_en); k++) tick(1);
        set_port(0, 2, 8'h60, 0);
        set_port(1, 2, 8'h70, 0);
        set_port(3, 2, 8'h80, 0);
        add_pkt(3, 2, 8'h80, 0);
        add_pkt(0, 2, 8'h60, 0);
        add_pkt(1, 2, 8'h70, 0);
        wait_beats(8);
        cmp_beats("R4");
    endtask

    // R6: valid gap inside a packet
    task automatic t_gap();
        do_reset();
        gap_at = 2;
        set_port(0, 5, 8'h90, 0);
        add_pkt(0, 5, 8'h90, 0);
        wait_beats(5);
        cmp_beats("R6");
    endtask

    // R9: error marker mid-packet and on the last byte
    task automatic t_err();
        do_reset();
        perr_mid = 1;
        set_port(3, 4, 8'hC0, 1);
        add_pkt(3, 4, 8'hC0, 1);
        wait_beats(4);
        cmp_beats("R9");
    endtask

    // R5, R10: junk bytes while enable is low
    task automatic t_ignore();
        do_reset();
        junk = 1;
        tick(30);
        junk = 0;
        tick(3);
        chk(obs_n == 0, "R5", "beats from bytes without enable", obs_n, 0);
        for (int k = 0; k < 30; k++)
            if (en_log[(base + k) % LOGN]) chk(0, "R10", "enable with no port ready", 1, 0);
    endtask

    initial begin
        t_idle();
        t_single();
        t_multi();
        t_rr();
        t_gap();
        t_err();
        t_ignore();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule